// File: doc/BRIEF.md
# Mixed Depth Pixel Selector

This block is a streaming scan-out stage that turns three frame planes into a stream of 24-bit RGB pixels, one per clock while the sink accepts them. It walks the raster for a display of up to 1024x768 pixels. For each position it puts out a linear address, `y*1024 + x`, that is shared by all three planes. The line pitch is always 1024 pixels, whatever active width is set. In return the block takes an 8-bit palette index, the low 24 bits of a direct-colour word (red in [23:16], green in [15:8], blue in [7:0]) and the top byte of a control word.

A control byte of 0x03 makes that pixel true-colour. Any other value sends the pixel's index through an external palette table, so indexed and true-colour pixels can sit side by side on one screen. A global index-only setting forces every pixel through the palette.

The pipeline has two register stages. The first holds the fetched plane data and the colour-source decision, and drives the palette address. The second registers the chosen colour together with start-of-line and start-of-frame flags. A ready input stalls the whole pipeline without losing or repeating any pixel.

Top module: `mixed_pixel_select`

## Requirements
- R1: While reset is asserted `out_valid` is 0. The first pixel after reset is address 0, and `out_valid` first rises after the second rising clock edge that follows reset release.
- R2: When the control byte (bits [31:24] of the control word) of a pixel equals 0x03, `out_rgb` equals bits [23:0] of that pixel's direct-colour word.
- R3: For any other control byte (for example 0x02, 0xFF or 0x00), `out_rgb` equals the palette entry at that pixel's 8-bit index.
- R4: Pixels come out in raster order. The plane address is `y*1024 + x`, with x running from 0 to width-1 and y running from 0 to height-1.
- R5: After the last pixel of the last line, the raster restarts at address 0 and the next frame begins.
- R6: `out_sol` is 1 exactly on pixels with x = 0. `out_sof` is 1 exactly on the pixel with x = 0 and y = 0.
- R7: When `cfg_index_only` is 1, the control byte and the direct colour have no effect and every pixel takes its palette colour.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_rgb`, `out_sol`, `out_sof` and `out_valid` hold steady. Every pixel is delivered exactly once.
- R9: A width of 0 or above 1024 is taken as 1024. A height of 0 or above 768 is taken as 768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | 11 | Active pixels per line; held stable outside reset |
| cfg_height | input | 10 | Active lines per frame; held stable outside reset |
| cfg_index_only | input | 1 | 1: every pixel uses the palette |
| pix_addr | output | 20 | Plane address `y*1024 + x` of the pixel being fetched |
| idx_in | input | 8 | Byte-plane index at `pix_addr`, same cycle |
| direct_rgb | input | 24 | Direct-colour word bits [23:0] at `pix_addr`, same cycle |
| ctrl_tag | input | 8 | Control word bits [31:24] at `pix_addr`, same cycle |
| pal_addr | output | 8 | Palette address |
| pal_rgb | input | 24 | Palette entry at `pal_addr`, same cycle |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output colour |
| out_sol | output | 1 | Output pixel starts a line |
| out_sof | output | 1 | Output pixel starts a frame |
| out_ready | input | 1 | Sink accepts the output pixel |

## Verification
Two situations are hard to reach. One is the end-of-line turn when the width is below the pitch. The other is a stall that lands right on a line or frame boundary, where a lost or doubled pixel would shift every later colour. The bench models the planes and the palette as arithmetic functions of the address. It sweeps small widths and heights, including one-pixel lines, a full 1024-pixel line and the clamped sizes, and it stalls the sink with periodic patterns so that stalls fall on every raster phase. Because the control byte cycles through 0x03, 0x02, 0xFF and 0x00 with a period of five, which does not match the line length, true-colour and indexed pixels land on both sides of each line wrap.

// File: rtl/mixed_pixel_select.sv
module mixed_pixel_select #(
  parameter int MAX_W = 1024,
  parameter int MAX_H = 768,
  parameter int PITCH = 1024,
  localparam int XW = $clog2(MAX_W + 1),
  localparam int YW = $clog2(MAX_H + 1),
  localparam int AW = $clog2(PITCH * MAX_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic          cfg_index_only,
  output logic [AW-1:0] pix_addr,
  input  logic [7:0]    idx_in,
  input  logic [23:0]   direct_rgb,
  input  logic [7:0]    ctrl_tag,
  output logic [7:0]    pal_addr,
  input  logic [23:0]   pal_rgb,
  output logic          out_valid,
  output logic [23:0]   out_rgb,
  output logic          out_sol,
  output logic          out_sof,
  input  logic          out_ready
);
  localparam int XC = $clog2(MAX_W);
  localparam int YC = $clog2(MAX_H);
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  logic [XC-1:0] x_cnt;
  logic [YC-1:0] y_cnt;
  logic [XW-1:0] eff_w;
  logic [YW-1:0] eff_h;
  logic          x_last, y_last, adv1, adv2;

  logic          v1, use1, sol1, sof1;
  logic [7:0]    idx1;
  logic [23:0]   dir1;

  assign eff_w  = (cfg_width == '0 || cfg_width > XW'(MAX_W)) ? XW'(MAX_W) : cfg_width;
  assign eff_h  = (cfg_height == '0 || cfg_height > YW'(MAX_H)) ? YW'(MAX_H) : cfg_height;
  assign x_last = XW'(x_cnt) == eff_w - 1'b1;
  assign y_last = YW'(y_cnt) == eff_h - 1'b1;
  assign adv2   = !out_valid || out_ready;
  assign adv1   = !v1 || adv2;

  assign pix_addr = AW'(y_cnt) * AW'(PITCH) + AW'(x_cnt);
  assign pal_addr = idx1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_cnt <= '0;
      y_cnt <= '0;
    end else if (adv1) begin
      x_cnt <= x_last ? '0 : x_cnt + 1'b1;
      if (x_last) y_cnt <= y_last ? '0 : y_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      use1 <= 1'b0;
      sol1 <= 1'b0;
      sof1 <= 1'b0;
      idx1 <= '0;
      dir1 <= '0;
    end else if (adv1) begin
      v1   <= 1'b1;
      use1 <= !cfg_index_only && ctrl_tag == DIRECT_TAG;
      sol1 <= x_cnt == '0;
      sof1 <= x_cnt == '0 && y_cnt == '0;
      idx1 <= idx_in;
      dir1 <= direct_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
    end else if (adv2) begin
      out_valid <= v1;
      out_rgb   <= use1 ? dir1 : pal_rgb;
      out_sol   <= sol1;
      out_sof   <= sof1;
    end
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_sol) && $stable(out_sof));

  p_sof_in_sol_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_sol);

  p_x_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    XW'(x_cnt) < eff_w && YW'(y_cnt) < eff_h);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    adv1 && !x_last |=> pix_addr == $past(pix_addr) + 1'b1);

  p_valid_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
endmodule

// File: tb/tb_mixed_pixel_select.sv
module tb_mixed_pixel_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_width = 11'd4;
  logic [9:0]  cfg_height = 10'd2;
  logic        cfg_index_only = 1'b0;
  logic [19:0] pix_addr;
  logic [7:0]  idx_in, ctrl_tag, pal_addr;
  logic [23:0] direct_rgb, pal_rgb, out_rgb;
  logic        out_valid, out_sol, out_sof;
  logic        out_ready = 1'b1;

  int applied = 0;
  int miscompares = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] m_idx(int a);
    return 8'(a * 7 + 3);
  endfunction
  function automatic logic [31:0] m_ctrl(int a);
    logic [7:0] t;
    case (a % 5)
      0: t = 8'h03;
      1: t = 8'h02;
      2: t = 8'hFF;
      3: t = 8'h00;
      default: t = 8'h03;
    endcase
    return {t, 24'(a * 13)};
  endfunction
  function automatic logic [31:0] m_dir(int a);
    return {8'hA5, 24'(a * 40503 + 11)};
  endfunction
  function automatic logic [23:0] m_pal(logic [7:0] i);
    return {i ^ 8'h5A, ~i, i + 8'd17};
  endfunction

  logic [31:0] cw, dw;
  always_comb begin
    cw         = m_ctrl(int'(pix_addr));
    dw         = m_dir(int'(pix_addr));
    ctrl_tag   = cw[31:24];
    direct_rgb = dw[23:0];
    idx_in     = m_idx(int'(pix_addr));
    pal_rgb    = m_pal(pal_addr);
  end

  mixed_pixel_select dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_index_only(cfg_index_only), .pix_addr(pix_addr), .idx_in(idx_in),
    .direct_rgb(direct_rgb), .ctrl_tag(ctrl_tag), .pal_addr(pal_addr),
    .pal_rgb(pal_rgb), .out_valid(out_valid), .out_rgb(out_rgb),
    .out_sol(out_sol), .out_sof(out_sof), .out_ready(out_ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  task automatic run(input int w, input int h, input bit io, input int n, input int rmode);
    int ew, eh, ex, ey, got, k, a;
    bit held;
    logic [23:0] h_rgb, exp_rgb;
    logic h_sol, h_sof;
    logic [31:0] c;
    ew = (w == 0 || w > 1024) ? 1024 : w;
    eh = (h == 0 || h > 768) ? 768 : h;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_width = 11'(w);
    cfg_height = 10'(h);
    cfg_index_only = io;
    out_ready = 1'b0;
    @(negedge clk);
    applied++;
    if (out_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 valid in reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    applied++;
    if (out_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 valid one edge after reset: actual %b expected 0", out_valid);
    end
    ex = 0; ey = 0; got = 0; k = 0; held = 0;
    h_rgb = '0; h_sol = 0; h_sof = 0;
    while (got < n) begin
      if (held) begin
        applied++;
        if (!out_valid || out_rgb !== h_rgb || out_sol !== h_sol || out_sof !== h_sof) begin
          miscompares++;
          $display("FAIL R8 stall hold: actual v%b %h %b%b expected v1 %h %b%b",
                   out_valid, out_rgb, out_sol, out_sof, h_rgb, h_sol, h_sof);
        end
      end
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (k % 7) != 2 && (k % 7) != 5;
        default: out_ready = (k % 12) >= 8;
      endcase
      k++;
      held = out_valid && !out_ready;
      h_rgb = out_rgb; h_sol = out_sol; h_sof = out_sof;
      if (out_valid && out_ready) begin
        a = ey * 1024 + ex;
        c = m_ctrl(a);
        exp_rgb = (!io && c[31:24] == 8'h03) ? m_dir(a)[23:0] : m_pal(m_idx(a));
        applied++;
        if (out_rgb !== exp_rgb) begin
          miscompares++;
          $display("FAIL %s/R4 colour at x%0d y%0d tag %h: actual %h expected %h",
                   io ? "R7" : (c[31:24] == 8'h03 ? "R2" : "R3"), ex, ey, c[31:24], out_rgb, exp_rgb);
        end
        applied++;
        if (out_sol !== (ex == 0) || out_sof !== (ex == 0 && ey == 0)) begin
          miscompares++;
          $display("FAIL R6/R5/R9 flags at x%0d y%0d: actual %b%b expected %b%b",
                   ex, ey, out_sol, out_sof, ex == 0, ex == 0 && ey == 0);
        end
        got++;
        ex++;
        if (ex == ew) begin
          ex = 0;
          ey = (ey + 1 == eh) ? 0 : ey + 1;
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    run(10, 4, 1'b0, 83, 1);
    run(1, 3, 1'b0, 8, 0);
    run(3, 2, 1'b0, 20, 2);
    run(7, 3, 1'b1, 45, 1);
    run(1024, 2, 1'b0, 2060, 1);
    run(0, 2, 1'b0, 1030, 0);
    run(2000, 1, 1'b0, 1030, 0);
    run(1, 0, 1'b0, 772, 0);
    run(1, 1000, 1'b0, 772, 1);
    run(5, 1, 1'b0, 23, 2);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule